// File: doc/BRIEF.md
# Windowed Register File with Sliding Name Mapping

This block stores a processor's general registers in a physical array that is larger than the set of 5-bit architectural names. A window pointer selects which slice of the array the 32 names currently reach. Each move of the window shifts the mapping by 16 physical entries. Consecutive windows therefore overlap by half: the upper 16 names of one window are the lower 16 names of the next.

A save command advances the window by one position and a restore command moves it back by one. Each move takes effect at the next clock edge. When the pointer runs past the last window or below the first one, it wraps around and a one-cycle wrap flag is raised, so that surrounding logic can react. Spilling registers to memory and trap handling are not part of this block.

The block has one write port and one read port. Both are addressed by architectural name and both are translated through the current window.

Top module: `wrf_window_regfile`

## Requirements
- R1: The physical index for architectural name n under window pointer w is (n + 16*w) mod P, where P = 16*(NWIN+1). A read returns the word most recently written to that physical index.
- R2: While rst_n is low and in the first cycle after release, cwp is 0 and wrap_pulse is 0.
- R3: With save_win=1 and restore_win=0 at a clock edge, cwp increases by one. From NWIN-1 it goes to 0.
- R4: With restore_win=1 and save_win=0 at a clock edge, cwp decreases by one. From 0 it goes to NWIN-1.
- R5: With save_win and restore_win both high or both low, cwp is unchanged.
- R6: wrap_pulse is 1 for exactly the one cycle after an edge at which the pointer wrapped (R3 or R4). Otherwise it is 0.
- R7: A write in the same cycle as a save or restore is placed using cwp as it stood before that move.
- R8: rd_data follows rd_name and cwp combinationally. A read of the entry that is being written in the same cycle returns the prior content; the new word is visible after the edge.
- R9: Name n+16 under window w and name n under window w+1 (0 <= n < 16, w < NWIN-1) reach the same physical entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save_win | input | 1 | Advance the window by one |
| restore_win | input | 1 | Move the window back by one |
| rd_name | input | 5 | Architectural name for the read port |
| rd_data | output | DATA_W | Word at the translated read index |
| wr_en | input | 1 | Write enable |
| wr_name | input | 5 | Architectural name for the write port |
| wr_data | input | DATA_W | Word to write |
| cwp | output | $clog2(NWIN) | Current window pointer |
| wrap_pulse | output | 1 | One-cycle flag after a pointer wrap |

## Verification
The hardest conditions to reach from the ports are the two wrap transitions and a write issued in the same cycle as a window move. Both need the pointer to be walked to a particular position first. The stimulus fills every name of every window in order, so the overlaps overwrite earlier words in a pattern the model predicts. It then rereads every window while stepping the pointer forward through the top wrap, and steps it backward through the bottom wrap. Finally, a write is combined with a save and the result is read back from both windows.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int NAME_W     = 5;
  localparam int WIN_STRIDE = 16;

  // physical slot reached by an architectural name under a window pointer
  function automatic int phys_index(input int name, input int win, input int entries);
    return (name + WIN_STRIDE * win) % entries;
  endfunction

  function automatic int phys_entries(input int nwin);
    return WIN_STRIDE * (nwin + 1);
  endfunction
endpackage

// File: rtl/wrf_window_ptr.sv
module wrf_window_ptr #(
  parameter int NWIN = 7,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd,
  input  logic          back,
  output logic [CW-1:0] cwp,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp  <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (fwd && !back) begin
        if (cwp == LAST) begin
          cwp  <= '0;
          wrap <= 1'b1;
        end else begin
          cwp <= cwp + 1'b1;
        end
      end else if (back && !fwd) begin
        if (cwp == '0) begin
          cwp  <= LAST;
          wrap <= 1'b1;
        end else begin
          cwp <= cwp - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wrf_name_map.sv
module wrf_name_map #(
  parameter int NWIN = 7,
  localparam int CW   = $clog2(NWIN),
  localparam int PHYS = wrf_pkg::phys_entries(NWIN),
  localparam int PW   = $clog2(PHYS)
) (
  input  logic [wrf_pkg::NAME_W-1:0] name,
  input  logic [CW-1:0]              win,
  output logic [PW-1:0]              phys
);
  assign phys = PW'(wrf_pkg::phys_index(int'(name), int'(win), PHYS));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 128,
  localparam int PW = $clog2(PHYS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [PHYS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/wrf_window_regfile.sv
module wrf_window_regfile #(
  parameter int DATA_W = 32,
  parameter int NWIN   = 7,
  localparam int CW   = $clog2(NWIN),
  localparam int PHYS = wrf_pkg::phys_entries(NWIN),
  localparam int PW   = $clog2(PHYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       save_win,
  input  logic                       restore_win,
  input  logic [wrf_pkg::NAME_W-1:0] rd_name,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wr_en,
  input  logic [wrf_pkg::NAME_W-1:0] wr_name,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [CW-1:0]              cwp,
  output logic                       wrap_pulse
);
  // port 0 = read, port 1 = write; both see the pointer before any move
  logic [wrf_pkg::NAME_W-1:0] port_name [2];
  logic [PW-1:0]              port_phys [2];
  logic [PW-1:0]              rd_phys;
  logic [PW-1:0]              wr_phys;

  assign port_name[0] = rd_name;
  assign port_name[1] = wr_name;

  wrf_window_ptr #(.NWIN(NWIN)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .fwd  (save_win),
    .back (restore_win),
    .cwp  (cwp),
    .wrap (wrap_pulse)
  );

  for (genvar p = 0; p < 2; p++) begin : g_map
    wrf_name_map #(.NWIN(NWIN)) u_map (
      .name(port_name[p]),
      .win (cwp),
      .phys(port_phys[p])
    );
  end

  assign rd_phys = port_phys[0];
  assign wr_phys = port_phys[1];

  wrf_storage #(.DATA_W(DATA_W), .PHYS(PHYS)) u_store (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_phys),
    .wdata(wr_data),
    .raddr(rd_phys),
    .rdata(rd_data)
  );
endmodule

// File: rtl/wrf_window_regfile_chk.sv
module wrf_window_regfile_chk #(
  parameter int NWIN = 7,
  localparam int CW   = $clog2(NWIN),
  localparam int PHYS = wrf_pkg::phys_entries(NWIN),
  localparam int PW   = $clog2(PHYS)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       save_win,
  input logic                       restore_win,
  input logic [CW-1:0]              cwp,
  input logic                       wrap_pulse,
  input logic [wrf_pkg::NAME_W-1:0] rd_name,
  input logic [wrf_pkg::NAME_W-1:0] wr_name,
  input logic [PW-1:0]              rd_phys,
  input logic [PW-1:0]              wr_phys
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  a_r1_rd_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phys[3:0] == rd_name[3:0]);
  a_r1_wr_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phys[3:0] == wr_name[3:0]);
  a_r2_cwp_range: assert property (@(posedge clk) disable iff (!rst_n)
    cwp <= LAST);
  a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
    (save_win && !restore_win) |=>
      cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1));
  a_r4_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_win && !save_win) |=>
      cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (save_win == restore_win) |=> $stable(cwp));
  a_r6_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((save_win && !restore_win && cwp == LAST) ||
     (restore_win && !save_win && cwp == '0)) |=> wrap_pulse);
  a_r6_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
    !((save_win && !restore_win && cwp == LAST) ||
      (restore_win && !save_win && cwp == '0)) |=> !wrap_pulse);
endmodule

bind wrf_window_regfile wrf_window_regfile_chk #(.NWIN(NWIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .save_win   (save_win),
  .restore_win(restore_win),
  .cwp        (cwp),
  .wrap_pulse (wrap_pulse),
  .rd_name    (rd_name),
  .wr_name    (wr_name),
  .rd_phys    (rd_phys),
  .wr_phys    (wr_phys)
);

// File: tb/wrf_window_regfile_test.sv
module wrf_window_regfile_test;
  localparam int DW   = 32;
  localparam int NW   = 7;
  localparam int CW   = $clog2(NW);
  localparam int NP   = 16 * (NW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          save_win = 1'b0, restore_win = 1'b0, wr_en = 1'b0;
  logic [4:0]    rd_name = '0, wr_name = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] cwp;
  logic          wrap_pulse;

  int errors = 0;
  int checks = 0;
  int mw = 0;                 // model window pointer
  logic [DW-1:0] model [NP];

  always #2 clk = ~clk;       // 250 MHz

  wrf_window_regfile #(.DATA_W(DW), .NWIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .save_win(save_win), .restore_win(restore_win),
    .rd_name(rd_name), .rd_data(rd_data), .wr_en(wr_en), .wr_name(wr_name),
    .wr_data(wr_data), .cwp(cwp), .wrap_pulse(wrap_pulse)
  );

  function automatic int slot(input int n, input int w);
    int s;
    s = n + w * 16;
    while (s >= NP) s = s - NP;
    return s;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic move(input bit fwd, input string req);
    int prev;
    bit wrapped;
    prev = mw;
    save_win = fwd;
    restore_win = !fwd;
    cyc();
    save_win = 1'b0;
    restore_win = 1'b0;
    if (fwd) begin
      wrapped = (prev == NW - 1);
      mw = wrapped ? 0 : prev + 1;
    end else begin
      wrapped = (prev == 0);
      mw = wrapped ? NW - 1 : prev - 1;
    end
    check(req, DW'(cwp), DW'(mw));
    check({req, "/R6 wrap"}, DW'(wrap_pulse), DW'(wrapped));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 cwp in reset", DW'(cwp), 0);
    check("R2 wrap in reset", DW'(wrap_pulse), 0);
    rst_n = 1'b1;
    cyc();
    check("R2 cwp after reset", DW'(cwp), 0);
    check("R2 wrap after reset", DW'(wrap_pulse), 0);

    // fill every name of every window, then step forward (R3, wrap at top)
    for (int w = 0; w < NW; w++) begin
      for (int n = 0; n < 32; n++) begin
        wr_en = 1'b1;
        wr_name = 5'(n);
        wr_data = 32'h5A00_0000 ^ DW'(w << 12) ^ DW'(n << 4) ^ DW'(w * n);
        model[slot(n, mw)] = wr_data;
        cyc();
      end
      wr_en = 1'b0;
      move(1'b1, "R3 save step");
    end
    cyc();
    check("R6 wrap is one cycle", DW'(wrap_pulse), 0);

    // reread every window (R1)
    for (int w = 0; w < NW; w++) begin
      for (int n = 0; n < 32; n++) begin
        rd_name = 5'(n);
        #1;
        check("R1 read mapped slot", rd_data, model[slot(n, mw)]);
      end
      @(negedge clk);
      move(1'b1, "R3 save sweep");
    end

    // overlap: upper half of window 2 equals lower half of window 3 (R9)
    move(1'b1, "R3 to w1");
    move(1'b1, "R3 to w2");
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] upper;
      rd_name = 5'(k + 16);
      #1;
      upper = rd_data;
      @(negedge clk);
      move(1'b1, "R3 up for overlap");
      rd_name = 5'(k);
      #1;
      check("R9 overlap", rd_data, upper);
      @(negedge clk);
      move(1'b0, "R4 back for overlap");
    end
    move(1'b0, "R4 to w1");
    move(1'b0, "R4 to w0");

    // restore wraps at bottom, then step all the way down (R4, R6)
    for (int s = 0; s < NW; s++) move(1'b0, "R4 restore step");
    check("R4 back at zero", DW'(cwp), 0);

    // both or neither command: no move (R5)
    save_win = 1'b1; restore_win = 1'b1;
    cyc();
    check("R5 both held", DW'(cwp), 0);
    check("R5 both no wrap", DW'(wrap_pulse), 0);
    save_win = 1'b0; restore_win = 1'b0;
    move(1'b1, "R3 to w1");
    cyc();
    check("R5 idle held", DW'(cwp), 1);
    save_win = 1'b1; restore_win = 1'b1;
    cyc();
    check("R5 both held at w1", DW'(cwp), 1);
    save_win = 1'b0; restore_win = 1'b0;

    // write together with a save lands in the old window (R7)
    wr_en = 1'b1; wr_name = 5'd3; wr_data = 32'hC0DE_0007; save_win = 1'b1;
    model[slot(3, mw)] = wr_data;
    cyc();
    wr_en = 1'b0; save_win = 1'b0; mw = mw + 1;
    check("R7 cwp moved", DW'(cwp), DW'(mw));
    rd_name = 5'd3;
    #1;
    check("R7 new window untouched", rd_data, model[slot(3, mw)]);
    @(negedge clk);
    move(1'b0, "R4 back for R7");
    rd_name = 5'd3;
    #1;
    check("R7 word in old window", rd_data, 32'hC0DE_0007);
    @(negedge clk);

    // same-cycle read of the entry being written (R8)
    rd_name = 5'd5; wr_name = 5'd5; wr_en = 1'b1; wr_data = 32'hBEEF_0008;
    #1;
    check("R8 old content before edge", rd_data, model[slot(5, mw)]);
    model[slot(5, mw)] = 32'hBEEF_0008;
    cyc();
    wr_en = 1'b0;
    check("R8 new content after edge", rd_data, 32'hBEEF_0008);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule